// File: doc/BRIEF.md
# Boot Source Latch and Low-Address Remapper

This block decides which memory a processor starts from and keeps that choice steady while the chip runs. It takes two inputs: a boot strap pin and an option bit. After reset it counts clock edges and captures both inputs on the fourth rising edge. It captures them again, in the same way, every time the chip comes out of standby. The two captured bits select one of three sources: main flash, system memory or SRAM.

The choice drives a live address translation. Any processor address inside the low 64 KiB window is moved onto the selected memory by adding that memory's base address. Higher addresses pass through unchanged.

The block also holds the processor in reset until the capture has happened. When it releases the processor, it issues the first two fetch addresses: word 0, which holds the initial stack value, and then word 4, which holds the entry point.

Top module: `boot_remap`

## Requirements
- R1: With the captured boot pin at 0, the source code on `boot_src` is 0 (main flash), whatever the option bit is.
- R2: With the captured boot pin at 1 and the option bit at 1, `boot_src` is 1 (system memory).
- R3: With the captured boot pin at 1 and the option bit at 0, `boot_src` is 2 (SRAM). The code 3 never appears.
- R4: Both inputs are captured on the fourth rising edge after reset is released. `cpu_run` is low through the first three edges and goes high on that fourth edge.
- R5: Once captured, the inputs are ignored. Changing them later leaves `boot_src` and the address translation unchanged until the next reset or standby exit.
- R6: `standby_exit` sampled high on a rising edge clears `cpu_run` on that edge. The inputs are captured again, and `cpu_run` rises again, on the fourth rising edge after that one.
- R7: On the edge where `cpu_run` rises, `fetch_valid` goes high with `fetch_addr` = 0x0000_0000. On the next edge `fetch_addr` becomes 0x0000_0004. On the edge after that, `fetch_valid` returns low.
- R8: A `cpu_addr` below 0x0001_0000 appears on `phys_addr` (combinationally) with a base added: 0x0800_0000 for flash, 0x1FFF_D800 for system memory, or 0x2000_0000 for SRAM.
- R9: A `cpu_addr` at or above 0x0001_0000 appears on `phys_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_pin | input | 1 | Boot strap pin |
| boot_opt | input | 1 | Option bit that picks between system memory and SRAM |
| standby_exit | input | 1 | One-cycle pulse when the chip leaves standby |
| cpu_addr | input | 32 | Address issued by the processor |
| phys_addr | output | 32 | Address after remapping |
| boot_src | output | 2 | Selected source: 0 flash, 1 system memory, 2 SRAM |
| cpu_run | output | 1 | High when the processor is released from reset |
| fetch_valid | output | 1 | High while a start-up fetch address is presented |
| fetch_addr | output | 32 | Start-up fetch address: 0, then 4 |

## Verification
Some behaviours are checked by assertions on every cycle:
- `cpu_run` rises only when the edge count reaches the capture point.
- A standby exit always pulls `cpu_run` low.
- The source stays put while the processor runs.
- Start-up fetches appear only while the processor is released.
- The code 3 is never produced.

Other behaviours can only be shown by the bench's scenarios:
- The exact edge on which `cpu_run` rises, both after reset and after standby exit.
- The decode of every pin and option combination.
- The added base values, and pass-through at the 64 KiB boundary.
- Inputs changed after the capture are ignored.

// File: rtl/boot_remap.sv
module boot_remap #(
  parameter int          LATCH_EDGE = 4,
  parameter logic [31:0] ALIAS_SPAN = 32'h0001_0000,
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
  parameter logic [31:0] SYS_BASE   = 32'h1FFF_D800,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_pin,
  input  logic        boot_opt,
  input  logic        standby_exit,
  input  logic [31:0] cpu_addr,
  output logic [31:0] phys_addr,
  output logic [1:0]  boot_src,
  output logic        cpu_run,
  output logic        fetch_valid,
  output logic [31:0] fetch_addr
);
  localparam int CW = $clog2(LATCH_EDGE + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(LATCH_EDGE);
  localparam logic [CW-1:0] CNT_LAST = CW'(LATCH_EDGE - 1);

  logic [CW-1:0] cnt;
  logic          held_pin, held_opt;
  logic [1:0]    fseq;
  logic [31:0]   base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      held_pin <= 1'b0;
      held_opt <= 1'b0;
      cpu_run  <= 1'b0;
      fseq     <= 2'd0;
    end else if (standby_exit) begin
      cnt     <= '0;
      cpu_run <= 1'b0;
      fseq    <= 2'd0;
    end else if (cnt != CNT_DONE) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_LAST) begin
        held_pin <= boot_pin;
        held_opt <= boot_opt;
        cpu_run  <= 1'b1;
        fseq     <= 2'd1;
      end
    end else if (fseq != 2'd0) begin
      fseq <= (fseq == 2'd1) ? 2'd2 : 2'd0;
    end
  end

  assign boot_src    = !held_pin ? 2'd0 : (held_opt ? 2'd1 : 2'd2);
  assign base        = (boot_src == 2'd0) ? FLASH_BASE :
                       (boot_src == 2'd1) ? SYS_BASE : SRAM_BASE;
  assign phys_addr   = (cpu_addr < ALIAS_SPAN) ? cpu_addr + base : cpu_addr;
  assign fetch_valid = (fseq != 2'd0);
  assign fetch_addr  = (fseq == 2'd2) ? 32'h0000_0004 : 32'h0000_0000;

  // R4
  release_at_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_run) |-> $past(cnt) == CNT_LAST);

  // R6
  standby_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_exit |=> !cpu_run);

  // R5
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && !standby_exit) |=> $stable(boot_src));

  // R7
  fetch_while_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> cpu_run);

  // R3
  src_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_src != 2'd3);
endmodule

// File: tb/boot_remap_test.sv
module boot_remap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_pin = 1'b0, boot_opt = 1'b0, standby_exit = 1'b0;
  logic [31:0] cpu_addr = 32'h0;
  logic [31:0] phys_addr, fetch_addr;
  logic [1:0]  boot_src;
  logic        cpu_run, fetch_valid;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  boot_remap uut (.clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .boot_opt(boot_opt),
    .standby_exit(standby_exit), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
    .boot_src(boot_src), .cpu_run(cpu_run), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr));

  // pin, opt, addr, expected src, expected phys
  localparam logic [67:0] VEC [8] = '{
    {1'b0, 1'b0, 32'h0000_0000, 2'd0, 32'h0800_0000},
    {1'b0, 1'b1, 32'h0000_1234, 2'd0, 32'h0800_1234},
    {1'b1, 1'b1, 32'h0000_0004, 2'd1, 32'h1FFF_D804},
    {1'b1, 1'b0, 32'h0000_FFFC, 2'd2, 32'h2000_FFFC},
    {1'b1, 1'b0, 32'h0001_0000, 2'd2, 32'h0001_0000},
    {1'b0, 1'b0, 32'h2000_0040, 2'd0, 32'h2000_0040},
    {1'b1, 1'b1, 32'h0000_FFFF, 2'd1, 32'h2000_D7FF},
    {1'b1, 1'b1, 32'h4001_3800, 2'd1, 32'h4001_3800}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start(input logic p, input logic o);
    @(negedge clk);
    boot_pin = p; boot_opt = o; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 run low before 4th edge", {31'b0, cpu_run}, 32'd0);
    @(negedge clk);
    check("R4 run high at 4th edge", {31'b0, cpu_run}, 32'd1);
  endtask

  initial begin
    fork
      begin
        #1;
        check("R4 reset run", {31'b0, cpu_run}, 32'd0);
        check("R7 reset fetch_valid", {31'b0, fetch_valid}, 32'd0);
        check("R1 reset src", {30'b0, boot_src}, 32'd0);
        for (int i = 0; i < 8; i++) begin
          start(VEC[i][67], VEC[i][66]);
          cpu_addr = VEC[i][65:34];
          #1;
          check(VEC[i][66:65] == 2'b00 && !VEC[i][67] ? "R1 src" :
                VEC[i][67] && VEC[i][66] ? "R2 src" : "R3 src",
                {30'b0, boot_src}, {30'b0, VEC[i][33:32]});
          check(VEC[i][65:34] < 32'h1_0000 ? "R8 remap" : "R9 passthrough",
                phys_addr, VEC[i][31:0]);
        end
        start(1'b1, 1'b0);
        check("R7 first fetch valid", {31'b0, fetch_valid}, 32'd1);
        check("R7 first fetch addr", fetch_addr, 32'h0);
        @(negedge clk);
        check("R7 second fetch valid", {31'b0, fetch_valid}, 32'd1);
        check("R7 second fetch addr", fetch_addr, 32'h4);
        @(negedge clk);
        check("R7 fetch ends", {31'b0, fetch_valid}, 32'd0);
        boot_pin = 1'b0; boot_opt = 1'b1; cpu_addr = 32'h0000_0010;
        repeat (3) @(negedge clk);
        check("R5 src ignores late pins", {30'b0, boot_src}, 32'd2);
        check("R5 remap ignores late pins", phys_addr, 32'h2000_0010);
        boot_pin = 1'b1; boot_opt = 1'b1;
        standby_exit = 1'b1;
        @(negedge clk);
        standby_exit = 1'b0;
        check("R6 run drops on standby exit", {31'b0, cpu_run}, 32'd0);
        repeat (3) @(negedge clk);
        check("R6 run low before resample", {31'b0, cpu_run}, 32'd0);
        check("R6 src held until resample", {30'b0, boot_src}, 32'd2);
        @(negedge clk);
        check("R6 run after resample", {31'b0, cpu_run}, 32'd1);
        check("R6 resampled src", {30'b0, boot_src}, 32'd1);
        check("R6 restart fetch addr", fetch_addr, 32'h0);
        check("R8 sysmem remap", phys_addr, 32'h1FFF_D810);
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule